// File: doc/BRIEF.md
# Masked Data Access Break Comparator

This block watches the data-memory bus of a processor and raises a break request when a single access meets a programmed condition. The condition has three terms, and all three must be true at once. The address must lie inside an inclusive window. The data must equal a reference value on every bit that is not ignored. The access direction must be allowed by a two-bit direction selector. Only one such condition exists.

The bus side is an observation port. Each access is presented for one clock, with the access strobe high. The comparator can never stall the bus, so the port has no ready signal and applies no back-pressure. Every strobed cycle is evaluated.

The break request is registered. It pulses high for one clock in the cycle after each qualifying access. Whatever logic halts the core consumes that pulse. Configuration arrives on plain static inputs.

Top module: `dbrk_access_break`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `brk_req` is 0.
- R2: The address term is true when `cfg_addr_lo <= acc_addr <= cfg_addr_hi`, compared as unsigned values. Both ends of the window qualify.
- R3: When `cfg_addr_lo > cfg_addr_hi`, no address qualifies and no break is raised.
- R4: The data term is true when `acc_data` equals `cfg_data_ref` on every bit where `cfg_data_ign` is 0. A bit of `cfg_data_ign` set to 1 makes that bit compare as equal.
- R5: The direction term uses `cfg_dir` with this encoding: 2'b00 means the check is off and any direction qualifies; 2'b01 means reads only (`acc_write`=0); 2'b10 means writes only (`acc_write`=1); 2'b11 means either direction.
- R6: A qualifying access in cycle N drives `brk_req` high in cycle N+1 only. Consecutive qualifying accesses give consecutive pulses.
- R7: A cycle with `acc_valid` low never causes a break, whatever the other bus inputs hold.
- R8: While `cfg_enable` is 0, no access causes a break.
- R9: If any one of the three terms is false, the access causes no break, even when the other two terms are true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Arms the break condition |
| cfg_addr_lo | input | 16 | Inclusive lower address bound |
| cfg_addr_hi | input | 16 | Inclusive upper address bound |
| cfg_data_ref | input | 4 | Reference data value |
| cfg_data_ign | input | 4 | Per-bit ignore mask; a 1 ignores that bit |
| cfg_dir | input | 2 | Direction selector (00 any, 01 read, 10 write, 11 either) |
| acc_valid | input | 1 | Bus access strobe, one cycle per access |
| acc_addr | input | 16 | Access address |
| acc_data | input | 4 | Access data |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| brk_req | output | 1 | One-cycle break request |

## Verification
The hardest case to reach from the ports is an access where exactly one term fails while the other two hold. An access that fails several terms at once proves nothing about the AND. The stimulus therefore starts from a fully qualifying access and breaks a single term at a time: an address one outside each window end, one unmasked data bit flipped, and the opposite direction under the read-only and write-only settings. It also runs back-to-back qualifying accesses to show that the pulses do not merge, and it inverts the window to cover the empty range.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
  typedef enum logic [1:0] {
    DIR_ANY    = 2'b00,
    DIR_READ   = 2'b01,
    DIR_WRITE  = 2'b10,
    DIR_EITHER = 2'b11
  } dir_sel_e;
endpackage

// File: rtl/dbrk_range_cmp.sv
module dbrk_range_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              in_range
);
  logic above_lo, below_hi;

  always_comb begin
    above_lo = (addr >= lo);
    below_hi = (addr <= hi);
    in_range = above_lo & below_hi;
  end

  // R3: an inverted window holds no address
  always_comb begin
    a_r3_empty_window: assert (!(lo > hi) || !in_range)
      else $error("range hit with lo > hi");
  end
endmodule

// File: rtl/dbrk_data_cmp.sv
module dbrk_data_cmp #(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] ref_val,
  input  logic [DATA_W-1:0] ign,
  output logic              match
);
  logic [DATA_W-1:0] bit_ok;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign bit_ok[i] = ign[i] | (data[i] == ref_val[i]);
    end
  endgenerate

  assign match = &bit_ok;

  // R4: a fully ignored compare always matches
  always_comb begin
    a_r4_all_ignored: assert (!(&ign) || match)
      else $error("fully masked data compare failed");
  end
endmodule

// File: rtl/dbrk_dir_cmp.sv
module dbrk_dir_cmp
  import dbrk_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       is_write,
  output logic       dir_ok
);
  always_comb begin
    unique case (dir_sel_e'(sel))
      DIR_READ:  dir_ok = ~is_write;
      DIR_WRITE: dir_ok = is_write;
      default:   dir_ok = 1'b1;
    endcase
  end

  // R5: the read-only setting rejects writes, and the write-only setting rejects reads
  always_comb begin
    a_r5_dir_exclusive: assert (!((sel == 2'b01 && is_write) || (sel == 2'b10 && !is_write)) || !dir_ok)
      else $error("direction term accepted a wrong direction");
  end
endmodule

// File: rtl/dbrk_access_break.sv
module dbrk_access_break #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [ADDR_W-1:0] cfg_addr_lo,
  input  logic [ADDR_W-1:0] cfg_addr_hi,
  input  logic [DATA_W-1:0] cfg_data_ref,
  input  logic [DATA_W-1:0] cfg_data_ign,
  input  logic [1:0]        cfg_dir,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic              acc_write,
  output logic              brk_req
);
  logic addr_hit, data_hit, dir_hit, qualify;

  dbrk_range_cmp #(.ADDR_W(ADDR_W)) u_range (
    .addr(acc_addr), .lo(cfg_addr_lo), .hi(cfg_addr_hi), .in_range(addr_hit)
  );

  dbrk_data_cmp #(.DATA_W(DATA_W)) u_data (
    .data(acc_data), .ref_val(cfg_data_ref), .ign(cfg_data_ign), .match(data_hit)
  );

  dbrk_dir_cmp u_dir (
    .sel(cfg_dir), .is_write(acc_write), .dir_ok(dir_hit)
  );

  assign qualify = cfg_enable & acc_valid & addr_hit & data_hit & dir_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) brk_req <= 1'b0;
    else        brk_req <= qualify;
  end

  // R6: a qualifying access is followed by a pulse in the next cycle
  a_r6_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && acc_valid && addr_hit && data_hit && dir_hit) |=> brk_req)
    else $error("missing break pulse");

  // R7: a cycle without an access raises no break
  a_r7_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !brk_req)
    else $error("break without access");

  // R8: a disarmed comparator raises no break
  a_r8_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !brk_req)
    else $error("break while disabled");

  // R9: any failing term blocks the break
  a_r9_and_terms: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_hit && data_hit && dir_hit) |=> !brk_req)
    else $error("break with a failing term");
endmodule

// File: tb/test_dbrk_access_break.sv
module test_dbrk_access_break;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [15:0] cfg_addr_lo = '0, cfg_addr_hi = '0;
  logic [3:0]  cfg_data_ref = '0, cfg_data_ign = '0;
  logic [1:0]  cfg_dir = 2'b00;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [3:0]  acc_data = '0;
  logic        acc_write = 1'b0;
  logic        brk_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;
  item_t sbq[$];

  always #5ns clk = ~clk;

  dbrk_access_break i_dbrk_access_break (
    .clk, .rst_n, .cfg_enable, .cfg_addr_lo, .cfg_addr_hi, .cfg_data_ref,
    .cfg_data_ign, .cfg_dir, .acc_valid, .acc_addr, .acc_data, .acc_write, .brk_req
  );

  function automatic bit model(bit en, bit v, logic [15:0] a, logic [3:0] d, bit w);
    bit ar, dr, wr;
    ar = (cfg_addr_lo <= a) && (a <= cfg_addr_hi);
    dr = (((d ^ cfg_data_ref) & ~cfg_data_ign) == 4'b0);
    case (cfg_dir)
      2'b01:   wr = !w;
      2'b10:   wr = w;
      default: wr = 1'b1;
    endcase
    return en && v && ar && dr && wr;
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: brk_req=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Driver: applies one bus cycle at the falling edge and queues its expected result.
  task automatic drive(bit v, logic [15:0] a, logic [3:0] d, bit w, string tag);
    item_t it;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_data = d; acc_write = w;
    it.exp = model(cfg_enable, v, a, d, w);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic setcfg(bit en, logic [15:0] lo, logic [15:0] hi,
                        logic [3:0] r, logic [3:0] m, logic [1:0] dir);
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_enable = en; cfg_addr_lo = lo; cfg_addr_hi = hi;
    cfg_data_ref = r; cfg_data_ign = m; cfg_dir = dir;
    sbq.push_back('{0, "R7 cfg idle"});
  endtask

  // Monitor: each registered result appears one edge after its access.
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #1ns;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(brk_req, it.exp, it.tag);
      end
    end
  end

  initial begin
    #2ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(brk_req, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1ns;
    check(brk_req, 1'b0, "R1 after reset");

    setcfg(1, 16'h0100, 16'h01FF, 4'hA, 4'h0, 2'b00);
    drive(1, 16'h0100, 4'hA, 0, "R2 low edge");
    drive(1, 16'h01FF, 4'hA, 1, "R2 high edge");
    drive(1, 16'h00FF, 4'hA, 0, "R9 below window");
    drive(1, 16'h0200, 4'hA, 0, "R9 above window");
    drive(1, 16'h0150, 4'hB, 0, "R9 data bit off");
    drive(0, 16'h0150, 4'hA, 0, "R7 no strobe");
    drive(1, 16'h0150, 4'hA, 0, "R6 back to back 1");
    drive(1, 16'h0151, 4'hA, 1, "R6 back to back 2");
    drive(0, 16'h0151, 4'hA, 1, "R6 single pulse");

    setcfg(1, 16'h0100, 16'h01FF, 4'hA, 4'h1, 2'b00);
    drive(1, 16'h0120, 4'hB, 0, "R4 ignored bit");
    drive(1, 16'h0120, 4'h2, 0, "R4 unmasked bit differs");
    setcfg(1, 16'h0100, 16'h01FF, 4'hA, 4'hF, 2'b00);
    drive(1, 16'h0120, 4'h5, 1, "R4 all ignored");

    setcfg(1, 16'h0100, 16'h01FF, 4'hA, 4'h0, 2'b01);
    drive(1, 16'h0130, 4'hA, 0, "R5 read only read");
    drive(1, 16'h0130, 4'hA, 1, "R5 read only write");
    setcfg(1, 16'h0100, 16'h01FF, 4'hA, 4'h0, 2'b10);
    drive(1, 16'h0130, 4'hA, 1, "R5 write only write");
    drive(1, 16'h0130, 4'hA, 0, "R5 write only read");
    setcfg(1, 16'h0100, 16'h01FF, 4'hA, 4'h0, 2'b11);
    drive(1, 16'h0130, 4'hA, 0, "R5 either read");
    drive(1, 16'h0130, 4'hA, 1, "R5 either write");

    setcfg(1, 16'h0300, 16'h0200, 4'hA, 4'hF, 2'b00);
    drive(1, 16'h0200, 4'hA, 0, "R3 inverted lo end");
    drive(1, 16'h0250, 4'hA, 0, "R3 inverted middle");
    drive(1, 16'h0300, 4'hA, 0, "R3 inverted hi end");

    setcfg(1, 16'h4000, 16'h4000, 4'h3, 4'h0, 2'b00);
    drive(1, 16'h4000, 4'h3, 0, "R2 single address");
    setcfg(0, 16'h4000, 16'h4000, 4'h3, 4'h0, 2'b00);
    drive(1, 16'h4000, 4'h3, 0, "R8 disabled");
    drive(1, 16'h4000, 4'h3, 1, "R8 disabled write");
    drive(0, 16'h0, 4'h0, 0, "R7 idle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule